// File: doc/BRIEF.md
# Sequenced Lookup-Table Function Evaluator

This block computes a wide Boolean function in time rather than in space. A compiler outside the block breaks the function into small sub-functions. Each one is a table with several inputs and several outputs, and all the tables sit together in one memory array of `LUT_ROWS` rows, each `LUT_W` bits wide. A short program held in a step store tells the sequencer, for each step, which row block to use, which bits form the row offset and which scratch register takes the result.

When a start pulse arrives, the primary input vector is captured. The sequencer then runs the programmed steps in order. In each step a routing stage builds the table address from constant zero, captured inputs or bits of earlier results. The memory returns the whole row one cycle later, and that row is written into a scratch register. After the last step a one-cycle done pulse is raised, and the selected scratch register appears on the result port. The table memory and the step store are filled through plain write ports while the block is idle.

Top module: `mbe_top`

## Requirements
- R1: Asserting `lut_we` stores `lut_wdata` at row `lut_waddr` of the table memory. Asserting `uc_we` stores `uc_wdata` as the program word for step `uc_waddr`.
- R2: Program word layout, starting from bit 0: select field k occupies bits [k*SEL_W +: SEL_W] for k = 0..ADDR_K-1. The next ROW_W bits hold the base row. The top REG_IW bits hold the destination register. A step reads row (base + sum of routed bit k times 2^k) modulo LUT_ROWS.
- R3: Source index encoding for a select field: 0 is constant zero, 1+i is primary input bit i as captured at start, and 1+N_IN+r*LUT_W+b is bit b of scratch register r. Any index beyond these reads as zero.
- R4: Steps run in order 0..S-1. Each step writes the full LUT_W-bit row it read into its destination register, and a later step routes the values written by earlier steps.
- R5: The step count S = `n_steps_m1`+1 (1 to 16) is sampled with start. `done` is high for exactly one cycle, beginning 2*S rising edges after the edge that accepted start.
- R6: A start request made while an evaluation is running, including the cycle in which `done` is high, is ignored. It neither restarts the evaluation nor changes the captured inputs, and it produces no extra done pulse.
- R7: `result` shows scratch register `res_sel`. When `done` is high it holds the value computed by the program.
- R8: After reset, `done` is 0 and every scratch register is 0, so `result` is 0.
- R9: `in_vec` is captured only on an accepted start. Changes to it during an evaluation have no effect on the outcome.
- R10: Scratch registers are not cleared by a new start. A register that the program does not write keeps its value from the previous evaluation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start request, accepted only when idle |
| in_vec | input | N_IN | Primary input vector |
| n_steps_m1 | input | STEP_W | Number of steps minus one |
| res_sel | input | REG_IW | Scratch register driven onto result |
| lut_we | input | 1 | Table memory write enable |
| lut_waddr | input | ROW_W | Table memory write row |
| lut_wdata | input | LUT_W | Table memory write data |
| uc_we | input | 1 | Step store write enable |
| uc_waddr | input | STEP_W | Step store write index |
| uc_wdata | input | UC_W | Program word |
| done | output | 1 | One-cycle completion pulse |
| result | output | LUT_W | Selected scratch register |

## Verification
The hardest part to reach from the ports is the chain of dependencies between steps: a wrong row can only show up after two routed intermediate values are combined. The bench therefore loads a two-level Shannon decomposition of a 6-input function. Four cofactors are produced in one step and then reduced by three multiplexing steps. The result is compared with a direct lookup for all 64 patterns of several random and constant truth tables. Start requests during a run and during the done cycle, together with input changes during a run, are injected to reach the ignore paths. A 16-step program with copy steps covers the maximum step count.

// File: rtl/mbe_pkg.sv
package mbe_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_WB    = 2'd2,
      ST_FIN   = 2'd3
   } mbe_state_e;
endpackage

// File: rtl/mbe_lut_mem.sv
module mbe_lut_mem #(
   parameter int ROWS = 64,
   parameter int W    = 4,
   localparam int AW  = $clog2(ROWS)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [AW-1:0] raddr,
   output logic [W-1:0]  rdata
);
   logic [W-1:0] mem_q [ROWS];

   // one-cycle read latency
   always_ff @(posedge clk) begin
      if (we) mem_q[waddr] <= wdata;
      rdata <= mem_q[raddr];
   end
endmodule

// File: rtl/mbe_ucode_store.sv
module mbe_ucode_store #(
   parameter int DEPTH = 16,
   parameter int UW    = 28,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [UW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [UW-1:0] rdata
);
   logic [UW-1:0] word_q [DEPTH];

   always_ff @(posedge clk) begin
      if (we) word_q[waddr] <= wdata;
   end

   assign rdata = word_q[raddr];
endmodule

// File: rtl/mbe_addr_route.sv
module mbe_addr_route #(
   parameter int K     = 4,
   parameter int SRC_W = 23,
   parameter int SEL_W = 5,
   parameter int ROW_W = 6
) (
   input  logic [SRC_W-1:0]   src,
   input  logic [K*SEL_W-1:0] sel_flat,
   input  logic [ROW_W-1:0]   base,
   output logic [ROW_W-1:0]   addr
);
   logic [K-1:0] off_bits;

   for (genvar k = 0; k < K; k++) begin : g_bit
      logic [SEL_W-1:0] sel_k;
      assign sel_k = sel_flat[k*SEL_W +: SEL_W];
      if ((1 << SEL_W) > SRC_W) begin : g_guard
         assign off_bits[k] = (int'(sel_k) < SRC_W) ? src[sel_k] : 1'b0;
      end else begin : g_direct
         assign off_bits[k] = src[sel_k];
      end
   end

   assign addr = base + ROW_W'(off_bits);
endmodule

// File: rtl/mbe_seq.sv
module mbe_seq
   import mbe_pkg::*;
#(
   parameter int N_IN   = 6,
   parameter int LUT_W  = 4,
   parameter int N_REG  = 4,
   parameter int STEP_W = 4,
   parameter int REG_IW = 2,
   localparam int IREG_W = N_REG * LUT_W,
   localparam int SRC_W  = 1 + N_IN + IREG_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [N_IN-1:0]   in_vec,
   input  logic [STEP_W-1:0] n_steps_m1,
   input  logic [LUT_W-1:0]  rdata,
   input  logic [REG_IW-1:0] dst,
   output mbe_state_e        st,
   output logic [STEP_W-1:0] step,
   output logic [STEP_W-1:0] last,
   output logic [IREG_W-1:0] ireg,
   output logic [SRC_W-1:0]  src,
   output logic              done
);
   mbe_state_e        st_q;
   logic [STEP_W-1:0] step_q, last_q;
   logic [N_IN-1:0]   in_q;
   logic [IREG_W-1:0] ireg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         step_q <= '0;
         last_q <= '0;
         in_q   <= '0;
         ireg_q <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: if (start) begin
               in_q   <= in_vec;
               last_q <= n_steps_m1;
               step_q <= '0;
               st_q   <= ST_ISSUE;
            end
            ST_ISSUE: st_q <= ST_WB;
            ST_WB: begin
               ireg_q[int'(dst)*LUT_W +: LUT_W] <= rdata;
               if (step_q == last_q) begin
                  st_q <= ST_FIN;
               end else begin
                  step_q <= step_q + 1'b1;
                  st_q   <= ST_ISSUE;
               end
            end
            ST_FIN: st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign st   = st_q;
   assign step = step_q;
   assign last = last_q;
   assign ireg = ireg_q;
   assign src  = {ireg_q, in_q, 1'b0};
   assign done = (st_q == ST_FIN);
endmodule

// File: rtl/mbe_top.sv
module mbe_top
   import mbe_pkg::*;
#(
   parameter int N_IN      = 6,
   parameter int LUT_W     = 4,
   parameter int LUT_ROWS  = 64,
   parameter int ADDR_K    = 4,
   parameter int N_REG     = 4,
   parameter int MAX_STEPS = 16,
   localparam int ROW_W  = $clog2(LUT_ROWS),
   localparam int SRC_W  = 1 + N_IN + N_REG * LUT_W,
   localparam int SEL_W  = $clog2(SRC_W),
   localparam int REG_IW = $clog2(N_REG),
   localparam int STEP_W = $clog2(MAX_STEPS),
   localparam int UC_W   = REG_IW + ROW_W + ADDR_K * SEL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [N_IN-1:0]   in_vec,
   input  logic [STEP_W-1:0] n_steps_m1,
   input  logic [REG_IW-1:0] res_sel,
   input  logic              lut_we,
   input  logic [ROW_W-1:0]  lut_waddr,
   input  logic [LUT_W-1:0]  lut_wdata,
   input  logic              uc_we,
   input  logic [STEP_W-1:0] uc_waddr,
   input  logic [UC_W-1:0]   uc_wdata,
   output logic              done,
   output logic [LUT_W-1:0]  result
);
   localparam int IREG_W = N_REG * LUT_W;

   initial begin : p_param_chk
      if (ADDR_K > ROW_W)        $error("ADDR_K exceeds table address width");
      if (N_REG < 2)             $error("N_REG must be at least 2");
      if ((1 << ROW_W) != LUT_ROWS)  $error("LUT_ROWS must be a power of two");
      if ((1 << STEP_W) != MAX_STEPS) $error("MAX_STEPS must be a power of two");
   end

   mbe_state_e        seq_st;
   logic [STEP_W-1:0] seq_step, seq_last;
   logic [IREG_W-1:0] ireg_flat;
   logic [SRC_W-1:0]  route_src;
   logic [UC_W-1:0]   uc_word;
   logic [ROW_W-1:0]  lut_raddr;
   logic [LUT_W-1:0]  lut_rdata;
   logic [REG_IW-1:0] uc_dst;
   logic [ROW_W-1:0]  uc_base;
   logic [ADDR_K*SEL_W-1:0] uc_sel;

   assign uc_sel  = uc_word[ADDR_K*SEL_W-1:0];
   assign uc_base = uc_word[ADDR_K*SEL_W +: ROW_W];
   assign uc_dst  = uc_word[UC_W-1 -: REG_IW];

   mbe_ucode_store #(.DEPTH(MAX_STEPS), .UW(UC_W)) u_ucode (
      .clk(clk), .we(uc_we), .waddr(uc_waddr), .wdata(uc_wdata),
      .raddr(seq_step), .rdata(uc_word)
   );

   mbe_addr_route #(.K(ADDR_K), .SRC_W(SRC_W), .SEL_W(SEL_W), .ROW_W(ROW_W)) u_route (
      .src(route_src), .sel_flat(uc_sel), .base(uc_base), .addr(lut_raddr)
   );

   mbe_lut_mem #(.ROWS(LUT_ROWS), .W(LUT_W)) u_lut (
      .clk(clk), .we(lut_we), .waddr(lut_waddr), .wdata(lut_wdata),
      .raddr(lut_raddr), .rdata(lut_rdata)
   );

   mbe_seq #(
      .N_IN(N_IN), .LUT_W(LUT_W), .N_REG(N_REG), .STEP_W(STEP_W), .REG_IW(REG_IW)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .in_vec(in_vec),
      .n_steps_m1(n_steps_m1), .rdata(lut_rdata), .dst(uc_dst),
      .st(seq_st), .step(seq_step), .last(seq_last), .ireg(ireg_flat),
      .src(route_src), .done(done)
   );

   assign result = ireg_flat[int'(res_sel)*LUT_W +: LUT_W];
endmodule

// File: rtl/mbe_chk.sv
module mbe_chk
   import mbe_pkg::*;
#(
   parameter int STEP_W = 4,
   parameter int IREG_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              done,
   input mbe_state_e        st,
   input logic [STEP_W-1:0] step,
   input logic [STEP_W-1:0] last,
   input logic [IREG_W-1:0] ireg
);
   a_r5_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r5_issue_then_wb: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_ISSUE) |=> (st == ST_WB));

   a_r4_step_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WB && step != last) |=> (st == ST_ISSUE && step == $past(step) + 1'b1));

   a_r6_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_ISSUE || st == ST_WB) |=> (st != ST_IDLE));

   a_r6_fin_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_FIN) |=> (st == ST_IDLE));

   a_r10_regs_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (st != ST_WB) |=> $stable(ireg));

   a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && !start) |=> (st == ST_IDLE && !done));
endmodule

bind mbe_top mbe_chk #(.STEP_W(STEP_W), .IREG_W(IREG_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .done(done), .st(seq_st),
   .step(seq_step), .last(seq_last), .ireg(ireg_flat)
);

// File: tb/tb_mbe_top.sv
module tb_mbe_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [5:0] in_vec = '0;
   logic [3:0] n_steps_m1 = '0;
   logic [1:0] res_sel = '0;
   logic       lut_we = 1'b0;
   logic [5:0] lut_waddr = '0;
   logic [3:0] lut_wdata = '0;
   logic       uc_we = 1'b0;
   logic [3:0] uc_waddr = '0;
   logic [27:0] uc_wdata = '0;
   logic       done;
   logic [3:0] result;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   mbe_top dut (
      .clk(clk), .rst_n(rst_n), .start(start), .in_vec(in_vec),
      .n_steps_m1(n_steps_m1), .res_sel(res_sel), .lut_we(lut_we),
      .lut_waddr(lut_waddr), .lut_wdata(lut_wdata), .uc_we(uc_we),
      .uc_waddr(uc_waddr), .uc_wdata(uc_wdata), .done(done), .result(result)
   );

   // source index encoding (R3)
   localparam int SRC_ZERO = 0;
   function automatic int src_in(int i);         return 1 + i; endfunction
   function automatic int src_reg(int r, int b); return 7 + r * 4 + b; endfunction

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic lut_wr(int row, int data);
      @(negedge clk);
      lut_we = 1'b1; lut_waddr = 6'(row); lut_wdata = 4'(data);
      @(negedge clk);
      lut_we = 1'b0;
   endtask

   // program word layout (R2): {dst, base, sel3, sel2, sel1, sel0}
   task automatic uc_wr(int idx, int dst, int base, int s0, int s1, int s2, int s3);
      @(negedge clk);
      uc_we = 1'b1; uc_waddr = 4'(idx);
      uc_wdata = {2'(dst), 6'(base), 5'(s3), 5'(s2), 5'(s1), 5'(s0)};
      @(negedge clk);
      uc_we = 1'b0;
   endtask

   function automatic logic [3:0] cof_word(logic [63:0] f, int x);
      int lo = x & 15;
      return {f[lo + 48], f[lo + 32], f[lo + 16], f[lo]};
   endfunction

   // R1 R2 R4: two-level Shannon split of a 6-input table
   task automatic load_table(logic [63:0] f);
      for (int r = 0; r < 16; r++) lut_wr(r, cof_word(f, r));
   endtask

   task automatic load_program();
      for (int blk = 16; blk <= 32; blk += 8)
         for (int o = 0; o < 8; o++)
            lut_wr(blk + o, o[2] ? int'(o[1]) : int'(o[0]));
      lut_wr(40, 0);
      lut_wr(41, 1);
      uc_wr(0, 0, 0,  src_in(0), src_in(1), src_in(2), src_in(3));
      uc_wr(1, 1, 16, src_reg(0, 0), src_reg(0, 1), src_in(4), SRC_ZERO);
      uc_wr(2, 2, 24, src_reg(0, 2), src_reg(0, 3), src_in(4), SRC_ZERO);
      uc_wr(3, 3, 32, src_reg(1, 0), src_reg(2, 0), src_in(5), SRC_ZERO);
      for (int s = 4; s < 16; s++)
         uc_wr(s, 3, 40, src_reg(3, 0), SRC_ZERO, SRC_ZERO, SRC_ZERO);
   endtask

   // returns latency in edges after acceptance and the result seen with done
   task automatic run_eval(int x, int nsm1, int rs, bit inject,
                           output int lat, output logic [3:0] res);
      @(negedge clk);
      in_vec = 6'(x); n_steps_m1 = 4'(nsm1); res_sel = 2'(rs); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      in_vec = 6'($urandom);                    // R9 disturbance
      lat = 0;
      while (!done && lat < 100) begin
         start = (inject && lat == 1);          // R6 start while running
         if (inject && lat == 1) n_steps_m1 = 4'd0;
         @(negedge clk);
         lat++;
      end
      start = 1'b0;
      res = result;
      if (lat >= 100) chk("R5 watchdog", lat, 2 * (nsm1 + 1));
   endtask

   int lat;
   logic [3:0] res;
   logic [63:0] tbl;

   initial begin : p_main
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      chk("R8 done at reset", int'(done), 0);
      chk("R8 result at reset", int'(result), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R8 done after reset", int'(done), 0);

      load_program();
      for (int t = 0; t < 4; t++) begin
         case (t)
            0: tbl = 64'h0;
            1: tbl = {$urandom, $urandom};
            2: tbl = {$urandom, $urandom};
            default: tbl = ~64'h0;
         endcase
         load_table(tbl);
         for (int x = 0; x < 64; x++) begin
            run_eval(x, 3, 3, (x % 7) == 3, lat, res);
            chk("R4 R7 function value", int'(res), int'(tbl[x]));
            chk("R5 latency", lat, 8);
            @(negedge clk);
            chk("R5 done single cycle", int'(done), 0);
         end
      end

      // R10: single step writes only reg0; reg3 keeps the last full result
      tbl = {$urandom, $urandom};
      load_table(tbl);
      run_eval(45, 3, 3, 1'b0, lat, res);
      chk("R7 full run", int'(res), int'(tbl[45]));
      run_eval(9, 0, 3, 1'b0, lat, res);
      chk("R10 unwritten register kept", int'(res), int'(tbl[45]));
      chk("R5 latency one step", lat, 2);
      run_eval(9, 0, 0, 1'b0, lat, res);
      chk("R4 cofactor word", int'(res), int'(cof_word(tbl, 9)));

      // R5 maximum step count with copy steps
      for (int k = 0; k < 4; k++) begin
         int x = int'($urandom % 64);
         run_eval(x, 15, 3, 1'b0, lat, res);
         chk("R5 latency sixteen steps", lat, 32);
         chk("R4 sixteen step value", int'(res), int'(tbl[x]));
      end

      // R6: start during the done cycle is ignored
      run_eval(17, 3, 3, 1'b0, lat, res);
      start = 1'b1; in_vec = 6'd50;
      @(negedge clk);
      start = 1'b0;
      begin
         int seen = 0;
         for (int c = 0; c < 30; c++) begin
            @(negedge clk);
            if (done) seen++;
         end
         chk("R6 no done after start in done cycle", seen, 0);
      end
      chk("R6 result unchanged", int'(result), int'(tbl[17]));

      // R2 R3: out-of-range select index reads as zero
      uc_wr(0, 1, 40, 31, SRC_ZERO, SRC_ZERO, SRC_ZERO);
      lut_wr(40, 5);
      lut_wr(41, 10);
      run_eval(63, 0, 1, 1'b0, lat, res);
      chk("R3 out of range index", int'(res), 5);
      uc_wr(0, 1, 40, src_in(5), SRC_ZERO, SRC_ZERO, SRC_ZERO);
      run_eval(32, 0, 1, 1'b0, lat, res);
      chk("R3 input bit routed", int'(res), 10);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin : p_watchdog
      #600000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule